// File: doc/BRIEF.md
# I2C Serial EEPROM Target with Current-Address Read

This block is the target side of an I2C bus that behaves like a small serial EEPROM. It watches SCL and SDA through synchronizers clocked by a system clock many times faster than SCL, and recognises START and STOP conditions. It matches the device address byte against a fixed prefix and three strap pins, and answers through an open-drain output enable. When the enable is high the pad pulls SDA low. When it is low, the line is released.

Reads are built around a current-address read. The target keeps an internal address counter and serves the byte it points at. If the master acknowledges after a byte, the target continues with the following address, and this continues until the master sends NACK and STOP. A short write path loads the counter: a word address byte, optionally followed by data bytes. That write path is used both for byte and page writes and for setting up a random read with a repeated START. The counter always holds the address the next read will return. A read moves it one past the last byte sent, and a write leaves it on the last byte written.

The array holds 256 or 512 bytes. In the 512-byte variant, one bit of the device address byte supplies the ninth bit of a word address instead of being compared with a strap.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_oe_o` is 0 and the address counter is 0, so a current read issued right after reset returns the byte at address 0. Array contents survive the reset.
- R2: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high, both seen on the synchronized lines. START begins a new address phase from any state, including a repeated START. STOP ends any transfer and releases SDA.
- R3: The device address byte is sent MSB first. Bits 7:4 must be 1010 and bit 0 is the direction (1 = read, 0 = write). With 512 bytes, bits 3:2 are compared with `strap_i[2:1]` and bit 1 is the page bit, which is never compared. With 256 bytes, bits 3:1 are compared with `strap_i[2:0]`. On a match the target pulls SDA low during the ninth SCL pulse.
- R4: On an address mismatch, SDA stays released until the next START. No byte is written and the address counter keeps its value.
- R5: Read data leaves MSB first, one bit per SCL pulse. `sda_oe_o` = 1 places a 0 on the line, and `sda_oe_o` = 0 leaves a 1.
- R6: After any read, a current read starts at the last byte sent plus one.
- R7: After a byte write or page write, a current read starts at the last byte written, with no increment.
- R8: While the master pulls SDA low in the acknowledge slot after a data byte, the target continues with the byte at the next address. Any number of bytes can be read this way, and the address wraps from the top of the array to 0.
- R9: When the master leaves SDA high in the acknowledge slot, the target releases SDA from the following SCL fall, drives nothing more, and the STOP ends the transfer.
- R10: In a write, the byte after the device address is the word address, and with 512 bytes the page bit is address bit 8. Each later byte is stored at consecutive addresses, wrapping at the top of the array. The target acknowledges every byte. A word address followed by a repeated START and a read returns data from that word address.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, raw |
| sda_i | input | 1 | Bus data line as seen on the wire, raw |
| strap_i | input | 3 | Device address strap pins |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Every target reaction comes three system clocks after the SCL edge that causes it: two synchronizer stages plus the state register. The bench changes SCL only every eight clocks and samples SDA four clocks into each high phase, long after the target's bit or ACK has settled. The NACK release is checked one half period after the acknowledge-slot fall. A monitor flags any change of `sda_oe_o` that coincides with SCL high. Random reads, current reads and writes run inside a window of pre-written addresses, and each is compared with a bench model of the array and the counter.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } ee_state_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output i2c_ee_pkg::bus_ev_t ev_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;
    logic scl_now, sda_now;

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sh   = {smp_q.scl_sh[SYNC_STAGES-2:0], scl_i};
        smp_d.sda_sh   = {smp_q.sda_sh[SYNC_STAGES-2:0], sda_i};
        smp_d.scl_prev = smp_q.scl_sh[SYNC_STAGES-1];
        smp_d.sda_prev = smp_q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_now = smp_q.scl_sh[SYNC_STAGES-1];
    assign sda_now = smp_q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        ev_o.scl_lvl  = scl_now;
        ev_o.sda_lvl  = sda_now;
        ev_o.scl_rise = scl_now & ~smp_q.scl_prev;
        ev_o.scl_fall = ~scl_now & smp_q.scl_prev;
        ev_o.start    = scl_now & smp_q.scl_prev & smp_q.sda_prev & ~sda_now;
        ev_o.stop     = scl_now & smp_q.scl_prev & ~smp_q.sda_prev & sda_now;
    end
endmodule

// File: rtl/ee_byte_store.sv
module ee_byte_store #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
    parameter int MEM_BYTES   = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    import i2c_ee_pkg::*;

    localparam int AW    = $clog2(MEM_BYTES);
    localparam bit PAGED = (AW > 8);

    typedef struct packed {
        ee_state_e     st;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic          rw;
        logic          pg;
        logic [AW-1:0] ptr;
        logic [AW-1:0] wptr;
        logic          oe;
        logic          mack;
    } core_t;

    core_t         cur_q, cur_d;
    bus_ev_t       ev;
    logic          dev_hit;
    logic          dev_pg;
    logic [AW-1:0] word_addr;
    logic          mem_we;
    logic [AW-1:0] mem_wa;
    logic [7:0]    mem_wd;
    logic [7:0]    mem_rd;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    ee_byte_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_wa),
        .wdata_i (mem_wd),
        .raddr_i (cur_q.ptr),
        .rdata_o (mem_rd)
    );

    generate
        if (PAGED) begin : g_paged
            logic unused_strap0;
            assign unused_strap0 = strap_i[0];
            assign dev_hit   = (cur_q.sh[7:4] == DEV_PREFIX) && (cur_q.sh[3:2] == strap_i[2:1]);
            assign dev_pg    = cur_q.sh[1];
            assign word_addr = AW'({cur_q.pg, cur_q.sh});
        end else begin : g_flat
            assign dev_hit   = (cur_q.sh[7:4] == DEV_PREFIX) && (cur_q.sh[3:1] == strap_i);
            assign dev_pg    = 1'b0;
            assign word_addr = AW'(cur_q.sh);
        end
    endgenerate

    always_comb begin
        cur_d  = cur_q;
        mem_we = 1'b0;
        mem_wa = cur_q.wptr;
        mem_wd = cur_q.sh;
        if (ev.stop) begin
            cur_d.st = ST_IDLE;
            cur_d.oe = 1'b0;
        end else if (ev.start) begin
            cur_d.st  = ST_DEV;
            cur_d.cnt = 4'd0;
            cur_d.oe  = 1'b0;
        end else begin
            unique case (cur_q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (ev.scl_rise) begin
                        cur_d.sh  = {cur_q.sh[6:0], ev.sda_lvl};
                        cur_d.cnt = cur_q.cnt + 4'd1;
                    end else if (ev.scl_fall && cur_q.cnt == 4'd8) begin
                        if (cur_q.st == ST_DEV) begin
                            if (dev_hit) begin
                                cur_d.st = ST_DEV_ACK;
                                cur_d.oe = 1'b1;
                                cur_d.rw = cur_q.sh[0];
                                cur_d.pg = dev_pg;
                            end else begin
                                cur_d.st = ST_IDLE;
                            end
                        end else if (cur_q.st == ST_WADDR) begin
                            cur_d.st   = ST_WADDR_ACK;
                            cur_d.oe   = 1'b1;
                            cur_d.wptr = word_addr;
                            cur_d.ptr  = word_addr;
                        end else begin
                            mem_we     = 1'b1;
                            cur_d.ptr  = cur_q.wptr;
                            cur_d.wptr = cur_q.wptr + AW'(1);
                            cur_d.st   = ST_WDATA_ACK;
                            cur_d.oe   = 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev.scl_fall) begin
                        cur_d.cnt = 4'd0;
                        if (cur_q.rw) begin
                            cur_d.st = ST_RDATA;
                            cur_d.sh = mem_rd;
                            cur_d.oe = ~mem_rd[7];
                        end else begin
                            cur_d.st = ST_WADDR;
                            cur_d.oe = 1'b0;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (ev.scl_fall) begin
                        cur_d.st  = ST_WDATA;
                        cur_d.cnt = 4'd0;
                        cur_d.oe  = 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_rise) begin
                        cur_d.cnt = cur_q.cnt + 4'd1;
                    end else if (ev.scl_fall) begin
                        if (cur_q.cnt == 4'd8) begin
                            cur_d.st  = ST_RACK;
                            cur_d.oe  = 1'b0;
                            cur_d.ptr = cur_q.ptr + AW'(1);
                        end else begin
                            cur_d.sh = {cur_q.sh[6:0], 1'b0};
                            cur_d.oe = ~cur_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        cur_d.mack = ~ev.sda_lvl;
                    end else if (ev.scl_fall) begin
                        if (cur_q.mack) begin
                            cur_d.st  = ST_RDATA;
                            cur_d.cnt = 4'd0;
                            cur_d.sh  = mem_rd;
                            cur_d.oe  = ~mem_rd[7];
                        end else begin
                            cur_d.st = ST_IDLE;
                            cur_d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign sda_oe_o = cur_q.oe;

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.oe) |-> !ev.scl_lvl);

    // R2
    start_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> (cur_q.st == ST_DEV) && (cur_q.cnt == 4'd0) && !cur_q.oe);

    // R4
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_IDLE) |-> !cur_q.oe);

    // R6
    rd_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RACK && $past(cur_q.st) == ST_RDATA) |-> cur_q.ptr == $past(cur_q.ptr) + AW'(1));

    // R10
    we_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> cur_q.oe && (cur_q.st == ST_WDATA_ACK));
endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
    localparam int MEM  = 512;
    localparam int HP   = 8;
    localparam int WBASE = 448;
    localparam int WLEN  = 128;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_oe;

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_eeprom_target #(.MEM_BYTES(MEM), .SYNC_STAGES(2)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .strap_i  (STRAP),
        .sda_oe_o (sda_oe)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int viol     = 0;
    bit done     = 0;
    bit oe_seen  = 0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_mem [MEM];
    logic [7:0] wbuf [256];
    int exp_ptr = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_oe && scl === 1'b1) viol++;
            if (sda_oe) oe_seen = 1'b1;
        end
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input bit pg, input bit rw, input logic [2:0] st);
        return {4'b1010, st[2], st[1], pg, rw};
    endfunction

    function automatic int wrap(input int a);
        return ((a % MEM) + MEM) % MEM;
    endfunction

    task automatic hp_wait();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hp_wait();
        scl = 1'b1;   hp_wait();
        m_sda = 1'b0; hp_wait();
        scl = 1'b0;   hp_wait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hp_wait();
        scl = 1'b1;   hp_wait();
        m_sda = 1'b1; hp_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hp_wait();
            scl = 1'b1;   hp_wait();
            scl = 1'b0;
        end
        m_sda = 1'b1; hp_wait();
        scl = 1'b1;
        repeat (HP/2) @(negedge clk);
        acked = ~sda_bus;
        repeat (HP/2) @(negedge clk);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp_wait();
            scl = 1'b1;
            repeat (HP/2) @(negedge clk);
            b[i] = sda_bus;
            repeat (HP/2) @(negedge clk);
            scl = 1'b0;
        end
        m_sda = mack ? 1'b0 : 1'b1;
        hp_wait();
        scl = 1'b1; hp_wait();
        scl = 1'b0;
    endtask

    task automatic read_n(input int n, input int base, input string tag);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n-1, b);
            chk(b === exp_mem[wrap(base+k)], tag, b, exp_mem[wrap(base+k)]);
        end
        hp_wait();
        chk(sda_oe === 1'b0, "R9 released after NACK", sda_oe, 0);
        bus_stop();
        chk(sda_oe === 1'b0, "R9 released after STOP", sda_oe, 0);
        exp_ptr = wrap(base + n);
    endtask

    task automatic wr_seq(input int addr, input int n);
        bit a;
        bus_start();
        send_byte(dev_byte(addr[8], 1'b0, STRAP), a);
        chk(a, "R3 write address ACK", a, 1);
        send_byte(addr[7:0], a);
        chk(a, "R10 word address ACK", a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            chk(a, "R10 data byte ACK", a, 1);
            exp_mem[wrap(addr+k)] = wbuf[k];
        end
        bus_stop();
        exp_ptr = wrap(addr + n - 1);
    endtask

    task automatic rand_read(input int addr, input int n, input string tag);
        bit a;
        bus_start();
        send_byte(dev_byte(addr[8], 1'b0, STRAP), a);
        chk(a, "R3 write address ACK", a, 1);
        send_byte(addr[7:0], a);
        chk(a, "R10 word address ACK", a, 1);
        bus_start();
        send_byte(dev_byte(1'b0, 1'b1, STRAP), a);
        chk(a, "R2 repeated START read ACK", a, 1);
        read_n(n, addr, tag);
    endtask

    task automatic cur_read(input int n, input string tag);
        bit a;
        bus_start();
        send_byte(dev_byte(1'b1, 1'b1, STRAP), a);
        chk(a, "R3 read address ACK", a, 1);
        read_n(n, exp_ptr, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic int win_addr(input int w);
        return wrap(WBASE + w);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit a;
        void'($urandom(32'd1234));
        do_reset();
        // R1
        chk(sda_oe === 1'b0, "R1 released after reset", sda_oe, 0);

        // R10: page write across the top of the array
        for (int k = 0; k < WLEN; k++) wbuf[k] = 8'($urandom);
        wr_seq(WBASE, WLEN);
        rand_read(508, 8, "R10 page write wrap readback");

        // R1: counter back to zero, contents kept
        do_reset();
        chk(sda_oe === 1'b0, "R1 released after second reset", sda_oe, 0);
        exp_ptr = 0;
        cur_read(1, "R1 current read after reset");
        cur_read(2, "R6 current read after read");

        // R5 and R7
        wbuf[0] = 8'h01;
        wr_seq(5, 1);
        cur_read(1, "R7 current read after byte write");
        wbuf[0] = 8'h80; wbuf[1] = 8'h7E; wbuf[2] = 8'hA5;
        wr_seq(6, 3);
        cur_read(1, "R7 current read after page write");
        cur_read(1, "R6 current read follows read");
        rand_read(6, 2, "R5 MSB first pattern");

        // R8: sequential read wraps
        rand_read(510, 5, "R8 sequential wrap");
        cur_read(2, "R6 after wrapped read");

        // R4: mismatching strap, write attempt ignored
        oe_seen = 1'b0;
        bus_start();
        send_byte(dev_byte(1'b0, 1'b0, STRAP ^ 3'b100), a);
        chk(!a, "R4 no ACK on strap mismatch", a, 0);
        send_byte(8'h00, a);
        chk(!a, "R4 no ACK on following byte", a, 0);
        send_byte(8'hEE, a);
        bus_stop();
        chk(!oe_seen, "R4 SDA never driven", oe_seen, 0);
        oe_seen = 1'b0;
        bus_start();
        send_byte({4'b1011, STRAP[2], STRAP[1], 1'b0, 1'b1}, a);
        chk(!a, "R4 no ACK on wrong prefix", a, 0);
        bus_stop();
        chk(!oe_seen, "R4 SDA never driven on wrong prefix", oe_seen, 0);
        cur_read(1, "R4 counter unchanged");
        rand_read(0, 1, "R4 byte not written");

        // mixed random traffic inside the written window
        for (int it = 0; it < 40; it++) begin
            int op = $urandom_range(0, 2);
            int n  = $urandom_range(1, 4);
            int w  = $urandom_range(0, WLEN - 1 - n);
            int wp = wrap(exp_ptr - WBASE);
            if (op == 0) begin
                rand_read(win_addr(w), n, "R10 random read");
            end else if (op == 1) begin
                if (wp + n <= WLEN) cur_read(n, "R6 R7 R8 current read");
                else rand_read(win_addr(w), n, "R10 random read");
            end else begin
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                wr_seq(win_addr(w), n);
            end
        end

        chk(viol == 0, "R11 SDA enable changed with SCL high", viol, 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule